// File: doc/BRIEF.md
# Product-Term Sharing Logic Block

This block evaluates the sum-of-products equations of one logic block of a programmable logic array. The block holds sixteen cells, each with five product terms. Each product term is an AND over a chosen set of true and complemented literals. The literals are the 40 fan-in signals plus a local feedback bus, which carries the combinational sum of every cell in the block. The feedback bus does not occupy fan-in slots.

A cell can be marked as a donor. A donor's product terms join the sum of the next higher-numbered cell, and the donor itself drives nothing. Several consecutive donors pass their terms up the chain into one receiving cell, so a single equation can use up to 40 product terms. The lowest cell has no predecessor, so it can never receive terms.

Configuration enters through two write ports, one for product terms and one for cell control. A checker flags four kinds of illegal setup. The first is a donor that is also in use or tied to a pin. The second is a donor at the top of the block, which has no receiver. The third is a borrow chain longer than the term limit allows. The fourth is a combinational loop through the feedback bus. Cell sums and error flags are registered, one cycle after their inputs.

Top module: `pterm_share_block`

## Requirements
- R1: A synchronous active-high reset clears all product-term and cell-control configuration. In the cycle after reset is released, sum_o and cfg_err_o are all zero.
- R2: Literals are numbered as follows: literal i for i < 40 is fan_in[i], and literal 40+j is the local feedback bit of cell j. An enabled product term is 1 exactly when every literal set in its true mask is 1 and every literal set in its complement mask is 0. An enabled term with both masks empty is constant 1. A disabled term contributes 0.
- R3: A cell's sum is the OR of its enabled product terms and all terms it receives. sum_o is registered: it reflects the inputs and configuration present before the clock edge that loads it.
- R4: When cell i-1 is a donor, cell i (for i ≥ 1) receives all terms that reach cell i-1, so terms chain through consecutive donors. Cell 0 never receives terms, and terms never wrap from the top cell to cell 0.
- R5: A donor cell drives 0 on its sum_o bit and 0 on its local feedback bit.
- R6: The local feedback bit of cell j is the combinational sum of cell j in the same cycle. Chains of feedback through several cells, in either index direction, settle within one cycle.
- R7: cfg_err_o[0] is set when any donor is also marked in use or pin-linked.
- R8: cfg_err_o[1] is set when the highest-numbered cell is a donor.
- R9: cfg_err_o[2] is set when more than 7 consecutive cells are donors, which means more than 40 product terms would feed one equation. A run of exactly 7 donors is legal.
- R10: cfg_err_o[3] is set when the feedback dependencies among non-donor cells form a cycle, including a self-loop. A receiver depends on the feedback literals used by every enabled term it receives. Feedback taken from a donor creates no dependency.
- R11: pt_we writes the enable and masks of term pt_idx of cell pt_cell, and ctl_we writes the control bits of cell ctl_cell. Both take effect at the next clock edge. A pt_idx of 5 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fan_in | input | 40 | Fan-in signals, literals 0 to 39 |
| pt_we | input | 1 | Product-term configuration write strobe |
| pt_cell | input | 4 | Cell addressed by a term write |
| pt_idx | input | 3 | Term index within the cell, 0 to 4 |
| pt_en | input | 1 | Enable of the written term |
| pt_true | input | 56 | Literals required to be 1 |
| pt_comp | input | 56 | Literals required to be 0 |
| ctl_we | input | 1 | Cell-control write strobe |
| ctl_cell | input | 4 | Cell addressed by a control write |
| ctl_in_use | input | 1 | Cell is used by the design |
| ctl_pin | input | 1 | Cell is tied to a pin |
| ctl_donate | input | 1 | Cell donates its terms upward |
| sum_o | output | 16 | Registered cell sums |
| cfg_err_o | output | 4 | Registered configuration error flags |

## Verification
Single terms are exercised with fan-in patterns that satisfy one mask, violate one true literal, or violate one complemented literal. These patterns separate the true-mask and complement-mask handling, and they also cover empty and contradictory masks. Borrowing is checked with donor runs of one, two and seven cells, with stimulus that activates only the donor's terms or only the receiver's own terms. This shows where the terms land, shows that donors stay silent, and shows that nothing wraps from the top cell to cell 0. Feedback patterns chain upward and downward through three cells and read a donor's feedback bit. The error patterns place each illegal setup next to a legal variant that differs from it by a single bit.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int ERR_W       = 4;
  localparam int ERR_CONFLICT = 0;
  localparam int ERR_TOPDON   = 1;
  localparam int ERR_CHAIN    = 2;
  localparam int ERR_LOOP     = 3;
endpackage

// File: rtl/pts_cfg_store.sv
module pts_cfg_store #(
  parameter int NCELL = 16,
  parameter int NPT   = 5,
  parameter int NLIT  = 56,
  parameter int CW    = 4,
  parameter int PW    = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  pt_we,
  input  logic [CW-1:0]                         pt_cell,
  input  logic [PW-1:0]                         pt_idx,
  input  logic                                  pt_en,
  input  logic [NLIT-1:0]                       pt_true,
  input  logic [NLIT-1:0]                       pt_comp,
  input  logic                                  ctl_we,
  input  logic [CW-1:0]                         ctl_cell,
  input  logic                                  ctl_in_use,
  input  logic                                  ctl_pin,
  input  logic                                  ctl_donate,
  output logic [NCELL-1:0][NPT-1:0]             en_q,
  output logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   true_q,
  output logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   comp_q,
  output logic [NCELL-1:0]                      in_use_q,
  output logic [NCELL-1:0]                      pin_q,
  output logic [NCELL-1:0]                      donate_q
);
  // Term storage: every entry is read in parallel each cycle, so flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      true_q <= '0;
      comp_q <= '0;
    end else if (pt_we) begin
      for (int c = 0; c < NCELL; c++) begin
        for (int p = 0; p < NPT; p++) begin
          if (pt_cell == CW'(c) && pt_idx == PW'(p)) begin
            en_q[c][p]   <= pt_en;
            true_q[c][p] <= pt_true;
            comp_q[c][p] <= pt_comp;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_use_q <= '0;
      pin_q    <= '0;
      donate_q <= '0;
    end else if (ctl_we) begin
      for (int c = 0; c < NCELL; c++) begin
        if (ctl_cell == CW'(c)) begin
          in_use_q[c] <= ctl_in_use;
          pin_q[c]    <= ctl_pin;
          donate_q[c] <= ctl_donate;
        end
      end
    end
  end
endmodule

// File: rtl/pts_eval.sv
module pts_eval #(
  parameter int NCELL = 16,
  parameter int NFAN  = 40,
  parameter int NPT   = 5,
  parameter int NLIT  = 56
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NFAN-1:0]                       fan_in,
  input  logic [NCELL-1:0][NPT-1:0]             en_q,
  input  logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   true_q,
  input  logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   comp_q,
  input  logic [NCELL-1:0]                      donate_q,
  input  logic                                  loop_err,
  output logic [NCELL-1:0]                      sum_c
);
  logic [NCELL-1:0][NPT-1:0] fan_ok;
  logic [NCELL-1:0]          fb_v;
  logic [NCELL-1:0]          fb_spare;

  // Fan-in half of every term: independent of feedback, computed once.
  always_comb begin
    for (int c = 0; c < NCELL; c++) begin
      for (int p = 0; p < NPT; p++) begin
        fan_ok[c][p] = en_q[c][p] &
          (&((~true_q[c][p][NFAN-1:0] | fan_in) &
             (~comp_q[c][p][NFAN-1:0] | ~fan_in)));
      end
    end
  end

  // One evaluation of all cells for a given feedback vector.
  function automatic logic [NCELL-1:0] eval_pass(
    input logic [NCELL-1:0]                     fb,
    input logic [NCELL-1:0][NPT-1:0]            fok,
    input logic [NCELL-1:0][NPT-1:0][NLIT-1:0]  tm,
    input logic [NCELL-1:0][NPT-1:0][NLIT-1:0]  cm,
    input logic [NCELL-1:0]                     don
  );
    logic [NCELL-1:0] res;
    logic             own;
    logic             chain;
    logic             carry;
    carry = 1'b0;  // nothing enters below cell 0
    for (int c = 0; c < NCELL; c++) begin
      own = 1'b0;
      for (int p = 0; p < NPT; p++) begin
        own = own | (fok[c][p] &
          (&((~tm[c][p][NLIT-1:NFAN] | fb) & (~cm[c][p][NLIT-1:NFAN] | ~fb))));
      end
      chain  = own | carry;
      res[c] = don[c] ? 1'b0 : chain;
      carry  = don[c] & chain;
    end
    return res;
  endfunction

  // Feedback settles in at most NCELL passes when the graph is acyclic.
  always_comb begin
    fb_v = '0;
    for (int it = 0; it < NCELL; it++) begin
      fb_v = eval_pass(fb_v, fan_ok, true_q, comp_q, donate_q);
    end
    sum_c    = fb_v;
    fb_spare = eval_pass(fb_v, fan_ok, true_q, comp_q, donate_q);
  end

  // R6: a loop-free configuration must have reached its fixed point.
  assert_fb_settles_R6: assert property (@(posedge clk) disable iff (rst)
    !loop_err |-> (fb_spare == sum_c));
endmodule

// File: rtl/pts_cfg_check.sv
module pts_cfg_check #(
  parameter int NCELL      = 16,
  parameter int NFAN       = 40,
  parameter int NPT        = 5,
  parameter int NLIT       = 56,
  parameter int MAX_DONORS = 7
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NCELL-1:0][NPT-1:0]             en_q,
  input  logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   true_q,
  input  logic [NCELL-1:0][NPT-1:0][NLIT-1:0]   comp_q,
  input  logic [NCELL-1:0]                      in_use_q,
  input  logic [NCELL-1:0]                      pin_q,
  input  logic [NCELL-1:0]                      donate_q,
  output logic [pts_pkg::ERR_W-1:0]             err_c
);
  import pts_pkg::*;

  logic [NCELL-1:0][NCELL-1:0] dep;
  logic [NCELL-1:0]            resolved;
  logic                        long_run;
  logic                        any_dep;

  // Dependency of each receiver on feedback bits, borrowed terms included.
  always_comb begin
    logic [NCELL-1:0] use_c;
    logic [NCELL-1:0] cu;
    logic [NCELL-1:0] carry;
    carry = '0;
    for (int c = 0; c < NCELL; c++) begin
      use_c = '0;
      for (int p = 0; p < NPT; p++) begin
        if (en_q[c][p]) use_c = use_c | true_q[c][p][NLIT-1:NFAN] | comp_q[c][p][NLIT-1:NFAN];
      end
      cu     = use_c | carry;
      dep[c] = donate_q[c] ? '0 : (cu & ~donate_q);
      carry  = donate_q[c] ? cu : '0;
    end
  end

  // Peel off cells whose dependencies are all resolved; leftovers mean a cycle.
  always_comb begin
    resolved = donate_q;
    for (int it = 0; it < NCELL; it++) begin
      for (int c = 0; c < NCELL; c++) begin
        if (!resolved[c] && ((dep[c] & ~resolved) == '0)) resolved[c] = 1'b1;
      end
    end
  end

  always_comb begin
    int run;
    run      = 0;
    long_run = 1'b0;
    for (int c = 0; c < NCELL; c++) begin
      if (donate_q[c]) run = run + 1;
      else             run = 0;
      if (run > MAX_DONORS) long_run = 1'b1;
    end
  end

  always_comb begin
    any_dep = 1'b0;
    for (int c = 0; c < NCELL; c++) any_dep = any_dep | (|dep[c]);
  end

  always_comb begin
    err_c               = '0;
    err_c[ERR_CONFLICT] = |(donate_q & (in_use_q | pin_q));
    err_c[ERR_TOPDON]   = donate_q[NCELL-1];
    err_c[ERR_CHAIN]    = long_run;
    err_c[ERR_LOOP]     = ~&resolved;
  end

  // R10: a reported loop needs at least one live feedback dependency.
  assert_loop_has_dep_R10: assert property (@(posedge clk) disable iff (rst)
    err_c[ERR_LOOP] |-> any_dep);
endmodule

// File: rtl/pterm_share_block.sv
module pterm_share_block #(
  parameter int NCELL  = 16,
  parameter int NFAN   = 40,
  parameter int NPT    = 5,
  parameter int MAX_PT = 40,
  localparam int NLIT       = NFAN + NCELL,
  localparam int CW         = $clog2(NCELL),
  localparam int PW         = $clog2(NPT),
  localparam int MAX_DONORS = MAX_PT / NPT - 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NFAN-1:0]             fan_in,
  input  logic                        pt_we,
  input  logic [CW-1:0]               pt_cell,
  input  logic [PW-1:0]               pt_idx,
  input  logic                        pt_en,
  input  logic [NLIT-1:0]             pt_true,
  input  logic [NLIT-1:0]             pt_comp,
  input  logic                        ctl_we,
  input  logic [CW-1:0]               ctl_cell,
  input  logic                        ctl_in_use,
  input  logic                        ctl_pin,
  input  logic                        ctl_donate,
  output logic [NCELL-1:0]            sum_o,
  output logic [pts_pkg::ERR_W-1:0]   cfg_err_o
);
  logic [NCELL-1:0][NPT-1:0]           en_q;
  logic [NCELL-1:0][NPT-1:0][NLIT-1:0] true_q;
  logic [NCELL-1:0][NPT-1:0][NLIT-1:0] comp_q;
  logic [NCELL-1:0]                    in_use_q;
  logic [NCELL-1:0]                    pin_q;
  logic [NCELL-1:0]                    donate_q;
  logic [NCELL-1:0]                    sum_c;
  logic [pts_pkg::ERR_W-1:0]           err_c;

  pts_cfg_store #(.NCELL(NCELL), .NPT(NPT), .NLIT(NLIT), .CW(CW), .PW(PW)) u_store (
    .clk(clk), .rst(rst),
    .pt_we(pt_we), .pt_cell(pt_cell), .pt_idx(pt_idx), .pt_en(pt_en),
    .pt_true(pt_true), .pt_comp(pt_comp),
    .ctl_we(ctl_we), .ctl_cell(ctl_cell), .ctl_in_use(ctl_in_use),
    .ctl_pin(ctl_pin), .ctl_donate(ctl_donate),
    .en_q(en_q), .true_q(true_q), .comp_q(comp_q),
    .in_use_q(in_use_q), .pin_q(pin_q), .donate_q(donate_q)
  );

  pts_cfg_check #(.NCELL(NCELL), .NFAN(NFAN), .NPT(NPT), .NLIT(NLIT),
                  .MAX_DONORS(MAX_DONORS)) u_check (
    .clk(clk), .rst(rst),
    .en_q(en_q), .true_q(true_q), .comp_q(comp_q),
    .in_use_q(in_use_q), .pin_q(pin_q), .donate_q(donate_q),
    .err_c(err_c)
  );

  pts_eval #(.NCELL(NCELL), .NFAN(NFAN), .NPT(NPT), .NLIT(NLIT)) u_eval (
    .clk(clk), .rst(rst), .fan_in(fan_in),
    .en_q(en_q), .true_q(true_q), .comp_q(comp_q), .donate_q(donate_q),
    .loop_err(err_c[pts_pkg::ERR_LOOP]),
    .sum_c(sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o     <= '0;
      cfg_err_o <= '0;
    end else begin
      sum_o     <= sum_c;
      cfg_err_o <= err_c;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_o == '0 && cfg_err_o == '0));

  assert_donor_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (sum_o & $past(donate_q)) == '0);

  assert_top_donor_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $past(donate_q[NCELL-1]) |-> cfg_err_o[pts_pkg::ERR_TOPDON]);
endmodule

// File: tb/pterm_share_block_bench.sv
module pterm_share_block_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 16;
  localparam int NFAN  = 40;
  localparam int NLIT  = 56;
  localparam int FB    = 40;

  logic              clk = 1'b0;
  logic              rst;
  logic [NFAN-1:0]   fan_in;
  logic              pt_we;
  logic [3:0]        pt_cell;
  logic [2:0]        pt_idx;
  logic              pt_en;
  logic [NLIT-1:0]   pt_true;
  logic [NLIT-1:0]   pt_comp;
  logic              ctl_we;
  logic [3:0]        ctl_cell;
  logic              ctl_in_use;
  logic              ctl_pin;
  logic              ctl_donate;
  logic [NCELL-1:0]  sum_o;
  logic [3:0]        cfg_err_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pterm_share_block u_pterm_share_block (
    .clk(clk), .rst(rst), .fan_in(fan_in),
    .pt_we(pt_we), .pt_cell(pt_cell), .pt_idx(pt_idx), .pt_en(pt_en),
    .pt_true(pt_true), .pt_comp(pt_comp),
    .ctl_we(ctl_we), .ctl_cell(ctl_cell), .ctl_in_use(ctl_in_use),
    .ctl_pin(ctl_pin), .ctl_donate(ctl_donate),
    .sum_o(sum_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [NLIT-1:0] L(input int i);
    return NLIT'(1) << i;
  endfunction

  function automatic logic [NFAN-1:0] F(input int i);
    return NFAN'(1) << i;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fan_in = '0; pt_we = 1'b0; ctl_we = 1'b0;
    pt_cell = '0; pt_idx = '0; pt_en = 1'b0; pt_true = '0; pt_comp = '0;
    ctl_cell = '0; ctl_in_use = 1'b0; ctl_pin = 1'b0; ctl_donate = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_pt(input int c, input int p, input logic en, input logic [NLIT-1:0] t, input logic [NLIT-1:0] m);
    @(negedge clk);
    pt_we = 1'b1; pt_cell = 4'(c); pt_idx = 3'(p); pt_en = en; pt_true = t; pt_comp = m;
    @(posedge clk);
    @(negedge clk);
    pt_we = 1'b0;
  endtask

  task automatic wr_ctl(input int c, input logic use_b, input logic pin_b, input logic don_b);
    @(negedge clk);
    ctl_we = 1'b1; ctl_cell = 4'(c); ctl_in_use = use_b; ctl_pin = pin_b; ctl_donate = don_b;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic drive(input logic [NFAN-1:0] f);
    @(negedge clk);
    fan_in = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "sum after reset", 32'(sum_o), 0);
    chk("R1", "err after reset", 32'(cfg_err_o), 0);
    wr_pt(2, 0, 1'b1, '0, '0);
    settle();
    chk("R2", "empty-mask term const 1", 32'(sum_o[2]), 1);
    do_reset();
    chk("R1", "config cleared by reset", 32'(sum_o), 0);
  endtask

  task automatic t_terms();
    do_reset();
    wr_pt(3, 0, 1'b1, L(0) | L(1), L(2));
    drive(F(0) | F(1));
    chk("R2", "masks satisfied", 32'(sum_o[3]), 1);
    drive(F(0) | F(1) | F(2));
    chk("R2", "complement literal high", 32'(sum_o[3]), 0);
    drive(F(0));
    chk("R2", "true literal low", 32'(sum_o[3]), 0);
    wr_pt(5, 1, 1'b1, '0, '0);
    settle();
    chk("R2", "empty masks", 32'(sum_o[5]), 1);
    wr_pt(5, 1, 1'b0, '0, '0);
    settle();
    chk("R2", "disabled term", 32'(sum_o[5]), 0);
    wr_pt(6, 2, 1'b1, L(4), L(4));
    drive(F(4));
    chk("R2", "contradictory term, lit high", 32'(sum_o[6]), 0);
    drive('0);
    chk("R2", "contradictory term, lit low", 32'(sum_o[6]), 0);
  endtask

  task automatic t_or_latency();
    do_reset();
    wr_pt(4, 0, 1'b1, L(5), '0);
    wr_pt(4, 4, 1'b1, L(6), '0);
    @(negedge clk);
    fan_in = F(5);
    #1;
    chk("R3", "output before edge still old", 32'(sum_o[4]), 0);
    settle();
    chk("R3", "term 0 after one edge", 32'(sum_o[4]), 1);
    drive(F(6));
    chk("R3", "term 4 alone", 32'(sum_o[4]), 1);
    drive('0);
    chk("R3", "no term true", 32'(sum_o[4]), 0);
  endtask

  task automatic t_borrow();
    do_reset();
    wr_ctl(7, 1'b0, 1'b0, 1'b1);
    wr_pt(7, 0, 1'b1, L(10), '0);
    wr_pt(8, 0, 1'b1, L(11), '0);
    drive(F(10));
    chk("R4", "receiver gets donor term", 32'(sum_o[8]), 1);
    chk("R5", "donor output silent", 32'(sum_o[7]), 0);
    drive(F(11));
    chk("R4", "receiver own term", 32'(sum_o[8]), 1);
    wr_ctl(6, 1'b0, 1'b0, 1'b1);
    wr_pt(6, 2, 1'b1, L(12), '0);
    drive(F(12));
    chk("R4", "two-donor chain", 32'(sum_o[8]), 1);
    chk("R5", "both donors silent", 32'(sum_o[7:6]), 0);
    wr_ctl(7, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R4", "chain now ends at cell 7", 32'(sum_o[8:7]), 32'b01);
    do_reset();
    wr_ctl(15, 1'b0, 1'b0, 1'b1);
    wr_pt(15, 0, 1'b1, '0, '0);
    settle();
    chk("R4", "no wrap into cell 0", 32'(sum_o[0]), 0);
    chk("R5", "top donor silent", 32'(sum_o[15]), 0);
    chk("R8", "top donor flag", 32'(cfg_err_o), 32'b0010);
    do_reset();
    wr_pt(2, 7, 1'b1, '0, '0);
    wr_pt(2, 5, 1'b1, '0, '0);
    settle();
    chk("R11", "out-of-range index ignored", 32'(sum_o[2]), 0);
  endtask

  task automatic t_feedback();
    do_reset();
    wr_pt(3, 0, 1'b1, L(0), '0);
    wr_pt(10, 0, 1'b1, L(FB + 3) | L(20), '0);
    wr_pt(11, 0, 1'b1, '0, L(FB + 10));
    wr_pt(9, 0, 1'b1, L(FB + 11), '0);
    drive(F(0) | F(20));
    chk("R6", "chain, cells 3 10 11 9", 32'({sum_o[3], sum_o[10], sum_o[11], sum_o[9]}), 32'b1100);
    drive(F(20));
    chk("R6", "chain flipped", 32'({sum_o[3], sum_o[10], sum_o[11], sum_o[9]}), 32'b0011);
    chk("R10", "acyclic feedback no flag", 32'(cfg_err_o), 0);
    do_reset();
    wr_ctl(7, 1'b0, 1'b0, 1'b1);
    wr_pt(7, 0, 1'b1, '0, '0);
    wr_pt(12, 0, 1'b1, L(FB + 7), '0);
    wr_pt(13, 0, 1'b1, L(FB + 8), '0);
    settle();
    chk("R5", "donor feedback bit low", 32'(sum_o[12]), 0);
    chk("R6", "receiver feedback carries borrowed sum", 32'(sum_o[13]), 1);
  endtask

  task automatic t_errors();
    do_reset();
    wr_ctl(4, 1'b1, 1'b0, 1'b1);
    settle();
    chk("R7", "in-use donor", 32'(cfg_err_o), 32'b0001);
    wr_ctl(4, 1'b0, 1'b1, 1'b1);
    settle();
    chk("R7", "pin-linked donor", 32'(cfg_err_o), 32'b0001);
    wr_ctl(4, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R7", "pin without donate", 32'(cfg_err_o), 0);

    do_reset();
    for (int c = 1; c <= 7; c++) wr_ctl(c, 1'b0, 1'b0, 1'b1);
    wr_pt(1, 0, 1'b1, L(30), '0);
    drive(F(30));
    chk("R9", "seven donors legal", 32'(cfg_err_o), 0);
    chk("R4", "40-term chain reaches cell 8", 32'(sum_o[8]), 1);
    wr_ctl(8, 1'b0, 1'b0, 1'b1);
    settle();
    chk("R9", "eight donors flagged", 32'(cfg_err_o), 32'b0100);

    do_reset();
    wr_pt(13, 0, 1'b1, L(FB + 14), '0);
    wr_pt(14, 0, 1'b1, L(FB + 13), '0);
    settle();
    chk("R10", "two-cell loop", 32'(cfg_err_o), 32'b1000);
    wr_pt(14, 0, 1'b0, L(FB + 13), '0);
    settle();
    chk("R10", "disabled term breaks loop", 32'(cfg_err_o), 0);
    wr_pt(2, 3, 1'b1, '0, L(FB + 2));
    settle();
    chk("R10", "self loop", 32'(cfg_err_o), 32'b1000);

    do_reset();
    wr_ctl(13, 1'b0, 1'b0, 1'b1);
    wr_pt(13, 0, 1'b1, L(FB + 14), '0);
    settle();
    chk("R10", "loop through borrowed term", 32'(cfg_err_o), 32'b1000);

    do_reset();
    wr_ctl(6, 1'b0, 1'b0, 1'b1);
    wr_pt(6, 0, 1'b1, L(FB + 5), '0);
    wr_pt(5, 0, 1'b1, '0, L(FB + 6));
    settle();
    chk("R10", "feedback from donor is no dependency", 32'(cfg_err_o), 0);
    chk("R5", "donor feedback reads 0", 32'(sum_o[5]), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog (all R): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_terms();
    t_or_latency();
    t_borrow();
    t_feedback();
    t_errors();
    summary();
    $finish;
  end
endmodule